// File: doc/BRIEF.md
# Queued Interrupt Dispatch Controller

This block handles interrupts for a small 16-bit processor. Interrupt messages are 16-bit words. They come from an external request port or from a software-interrupt operation, and they wait in a circular message queue. When the core reports that an instruction has finished, the controller decides whether to deliver the oldest waiting message. To deliver it, the controller saves the program counter and then general register A below the stack pointer through a stack write port. It then sends the core new values for PC (the handler address), A (the message) and SP.

The core also issues interrupt-related operations to the block on an operation port. These operations read or write the handler-address register, switch the queue-only mode on or off, raise a software interrupt, and return from a handler. Each operation takes a fixed number of cycles. Returning from a handler reads A and then PC back through the same stack port, clears the queue-only mode, and sends the restored values to the core. While queue-only mode is on, messages keep collecting but none is delivered. When the handler address is zero, a message taken at an instruction boundary is discarded.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After synchronous reset the queue is empty, queue-only mode is off, the overflow flag is clear, the handler address reads as zero, and busy is low.
- R2: Messages are delivered in arrival order. The queue has DEPTH slots (a power of two), holds at most DEPTH-1 messages, and its indices wrap around.
- R3: When an external request and a software interrupt enqueue in the same cycle, the external message is stored first and is delivered first.
- R4: An enqueue that makes the write index equal to the read index sets the overflow flag. The flag stays set until reset.
- R5: A delivery starts only on an instruction-boundary pulse that arrives while the block is idle, with no operation request, with queue-only mode off and with the queue non-empty. A boundary pulse under any other condition leaves the block idle.
- R6: When the handler address is zero, a boundary pulse that qualifies under R5 removes the oldest message and does nothing else: no stack write, no register write and no done pulse.
- R7: A delivery takes 3 cycles after the boundary edge. Cycle 0 writes PC to SP-1. Cycle 1 writes A to SP-2. Cycle 2 raises done with PC=handler address, A=message and SP=SP-2. Queue-only mode is set from cycle 0.
- R8: Return (op code 4) clears queue-only mode. It reads A from SP in cycle 0 and PC from SP+1 in cycle 1. In cycle 2 it raises done with those values and SP+2, for a total of 3 cycles.
- R9: Queue control (op code 2) turns queue-only mode on for a non-zero operand and off for a zero operand. It completes in 2 cycles.
- R10: Software interrupt (op code 3) enqueues its operand only when the handler address is non-zero. It completes in 4 cycles in both cases.
- R11: Handler-address read (op code 0) returns the register on `result`. Handler-address write (op code 1) loads the operand. Each completes in 1 cycle.
- R12: Op codes 5 to 7 complete in 1 cycle and change neither the handler address nor queue-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_valid | input | 1 | External message enqueue strobe |
| ext_req_msg | input | 16 | External message word |
| op_valid | input | 1 | Operation request, accepted when busy is low |
| op_kind | input | 3 | Operation code (0 read handler, 1 write handler, 2 queue control, 3 software interrupt, 4 return) |
| op_operand | input | 16 | Operation operand |
| insn_done | input | 1 | Instruction-boundary pulse from the core |
| cpu_pc | input | 16 | Core program counter |
| cpu_sp | input | 16 | Core stack pointer |
| cpu_a | input | 16 | Core register A |
| stk_rdata | input | 16 | Stack read data, valid in the same cycle as stk_re |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 16 | Stack word address |
| stk_wdata | output | 16 | Stack write data |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 16 | New program counter |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 16 | New stack pointer |
| a_we | output | 1 | Register A write strobe |
| a_wdata | output | 16 | New register A |
| result | output | 16 | Handler address returned by a read operation |
| done | output | 1 | Last cycle of an operation or delivery |
| busy | output | 1 | Operation or delivery in progress |
| queue_mode | output | 1 | Queue-only mode flag |
| fatal_ovf | output | 1 | Sticky queue overflow flag |
| q_empty | output | 1 | Message queue empty |

## Verification
Two enqueues can land in the same clock edge: an external request and a software interrupt. The bench raises both on one edge and then delivers the queue. The external message must come out first and the software message second. A delivery can also remove a message on the same edge as an external enqueue. The wrap-around sweep allows for this by enqueuing only up to capacity, and the overflow test fills an idle queue one slot past capacity to show exactly where the flag rises.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam logic [2:0] OPC_IA_RD = 3'd0;
  localparam logic [2:0] OPC_IA_WR = 3'd1;
  localparam logic [2:0] OPC_QCTL  = 3'd2;
  localparam logic [2:0] OPC_SWINT = 3'd3;
  localparam logic [2:0] OPC_RETI  = 3'd4;

  localparam int unsigned QCTL_CYCLES  = 2;
  localparam int unsigned SWINT_CYCLES = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_D_PC,
    ST_D_A,
    ST_D_FIN,
    ST_R_A,
    ST_R_PC,
    ST_R_FIN,
    ST_WAIT,
    ST_FIN
  } seq_st_t;

endpackage

// File: rtl/irqd_msg_fifo.sv
module irqd_msg_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr0_en,
  input  logic [W-1:0] wr0_data,
  input  logic         wr1_en,
  input  logic [W-1:0] wr1_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [AW-1:0] tail_1, tail_2, head_n;

  assign tail_1 = tail_q + {{(AW-1){1'b0}}, wr0_en};
  assign tail_2 = tail_1 + {{(AW-1){1'b0}}, wr1_en};
  assign head_n = head_q + {{(AW-1){1'b0}}, rd_en};

  assign empty    = (head_q == tail_q);
  assign rd_data  = empty ? '0 : mem[head_q];
  assign overflow = (wr0_en && (tail_1 == head_n)) || (wr1_en && (tail_2 == head_n));

  always_ff @(posedge clk) begin
    if (wr0_en) mem[tail_q] <= wr0_data;
    if (wr1_en) mem[tail_1] <= wr1_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_2;
    end
  end

  a_r2_read_only_when_filled: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  a_r2_second_write_follows_first: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && wr1_en && !rd_en) |=> (tail_q == $past(tail_q) + AW'(2)));

endmodule

// File: rtl/irqd_sequencer.sv
module irqd_sequencer
  import irqd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_kind,
  input  logic [W-1:0] op_operand,
  input  logic         insn_done,
  input  logic [W-1:0] cpu_pc,
  input  logic [W-1:0] cpu_sp,
  input  logic [W-1:0] cpu_a,
  input  logic         q_empty,
  input  logic [W-1:0] q_msg,
  input  logic [W-1:0] stk_rdata,
  output logic         deq_en,
  output logic         sw_en,
  output logic [W-1:0] sw_data,
  output logic         stk_we,
  output logic         stk_re,
  output logic [W-1:0] stk_addr,
  output logic [W-1:0] stk_wdata,
  output logic         pc_we,
  output logic [W-1:0] pc_wdata,
  output logic         sp_we,
  output logic [W-1:0] sp_wdata,
  output logic         a_we,
  output logic [W-1:0] a_wdata,
  output logic [W-1:0] result,
  output logic         done,
  output logic         busy,
  output logic         queue_mode
);

  localparam int CW = $clog2(SWINT_CYCLES);

  seq_st_t       state;
  logic [W-1:0]  ia_q, pc_q, a_q, sp_q, msg_q, res_q;
  logic [CW-1:0] cnt_q;
  logic          qmode_q;
  logic          idle, accept_op, take_bnd, ia_set;

  assign idle      = (state == ST_IDLE);
  assign ia_set    = (ia_q != '0);
  assign accept_op = idle && op_valid;
  assign take_bnd  = idle && !op_valid && insn_done && !qmode_q && !q_empty;

  assign deq_en  = take_bnd;
  assign sw_en   = accept_op && (op_kind == OPC_SWINT) && ia_set;
  assign sw_data = op_operand;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ia_q    <= '0;
      qmode_q <= 1'b0;
      cnt_q   <= '0;
      pc_q    <= '0;
      a_q     <= '0;
      sp_q    <= '0;
      msg_q   <= '0;
      res_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept_op) begin
            unique case (op_kind)
              OPC_IA_RD: begin
                res_q <= ia_q;
                state <= ST_FIN;
              end
              OPC_IA_WR: begin
                ia_q  <= op_operand;
                state <= ST_FIN;
              end
              OPC_QCTL: begin
                qmode_q <= (op_operand != '0);
                cnt_q   <= CW'(QCTL_CYCLES - 2);
                state   <= ST_WAIT;
              end
              OPC_SWINT: begin
                cnt_q <= CW'(SWINT_CYCLES - 2);
                state <= ST_WAIT;
              end
              OPC_RETI: begin
                qmode_q <= 1'b0;
                sp_q    <= cpu_sp;
                state   <= ST_R_A;
              end
              default: state <= ST_FIN;
            endcase
          end else if (take_bnd && ia_set) begin
            qmode_q <= 1'b1;
            pc_q    <= cpu_pc;
            a_q     <= cpu_a;
            sp_q    <= cpu_sp;
            msg_q   <= q_msg;
            state   <= ST_D_PC;
          end
        end
        ST_D_PC:  state <= ST_D_A;
        ST_D_A:   state <= ST_D_FIN;
        ST_R_A: begin
          a_q   <= stk_rdata;
          state <= ST_R_PC;
        end
        ST_R_PC: begin
          pc_q  <= stk_rdata;
          state <= ST_R_FIN;
        end
        ST_WAIT: begin
          if (cnt_q == '0) state <= ST_FIN;
          else             cnt_q <= cnt_q - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stk_we    = (state == ST_D_PC) || (state == ST_D_A);
    stk_re    = (state == ST_R_A) || (state == ST_R_PC);
    stk_wdata = (state == ST_D_PC) ? pc_q : a_q;
    unique case (state)
      ST_D_PC: stk_addr = sp_q - W'(1);
      ST_D_A:  stk_addr = sp_q - W'(2);
      ST_R_PC: stk_addr = sp_q + W'(1);
      default: stk_addr = sp_q;
    endcase
  end

  assign pc_we    = (state == ST_D_FIN) || (state == ST_R_FIN);
  assign sp_we    = pc_we;
  assign a_we     = pc_we;
  assign pc_wdata = (state == ST_D_FIN) ? ia_q  : pc_q;
  assign a_wdata  = (state == ST_D_FIN) ? msg_q : a_q;
  assign sp_wdata = (state == ST_D_FIN) ? sp_q - W'(2) : sp_q + W'(2);

  assign done       = pc_we || (state == ST_FIN);
  assign busy       = !idle;
  assign result     = res_q;
  assign queue_mode = qmode_q;

  a_r7_push_a_below_pc: assert property (@(posedge clk) disable iff (rst)
    (state == ST_D_PC) |=> (stk_we && (stk_addr == $past(stk_addr) - W'(1))));

  a_r7_delivery_holds_queue_mode: assert property (@(posedge clk) disable iff (rst)
    (stk_we || (state == ST_D_FIN)) |-> queue_mode);

  a_r8_return_reads_upward: assert property (@(posedge clk) disable iff (rst)
    (stk_re && !$past(stk_re)) |=> (stk_re && (stk_addr == $past(stk_addr) + W'(1))));

  a_r8_return_clears_mode: assert property (@(posedge clk) disable iff (rst)
    stk_re |-> !queue_mode);

  a_r11_handler_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ia_q));

  a_r12_done_returns_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  a_r7_no_read_write_clash: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && stk_re));

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
  parameter int DEPTH = 256,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_req_valid,
  input  logic [W-1:0] ext_req_msg,
  input  logic         op_valid,
  input  logic [2:0]   op_kind,
  input  logic [W-1:0] op_operand,
  input  logic         insn_done,
  input  logic [W-1:0] cpu_pc,
  input  logic [W-1:0] cpu_sp,
  input  logic [W-1:0] cpu_a,
  input  logic [W-1:0] stk_rdata,
  output logic         stk_we,
  output logic         stk_re,
  output logic [W-1:0] stk_addr,
  output logic [W-1:0] stk_wdata,
  output logic         pc_we,
  output logic [W-1:0] pc_wdata,
  output logic         sp_we,
  output logic [W-1:0] sp_wdata,
  output logic         a_we,
  output logic [W-1:0] a_wdata,
  output logic [W-1:0] result,
  output logic         done,
  output logic         busy,
  output logic         queue_mode,
  output logic         fatal_ovf,
  output logic         q_empty
);

  logic         deq_en, sw_en, ovf_pulse, fatal_q;
  logic [W-1:0] sw_data, q_msg;

  irqd_msg_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr0_en   (ext_req_valid),
    .wr0_data (ext_req_msg),
    .wr1_en   (sw_en),
    .wr1_data (sw_data),
    .rd_en    (deq_en),
    .rd_data  (q_msg),
    .empty    (q_empty),
    .overflow (ovf_pulse)
  );

  irqd_sequencer #(.W(W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_operand (op_operand),
    .insn_done  (insn_done),
    .cpu_pc     (cpu_pc),
    .cpu_sp     (cpu_sp),
    .cpu_a      (cpu_a),
    .q_empty    (q_empty),
    .q_msg      (q_msg),
    .stk_rdata  (stk_rdata),
    .deq_en     (deq_en),
    .sw_en      (sw_en),
    .sw_data    (sw_data),
    .stk_we     (stk_we),
    .stk_re     (stk_re),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata),
    .sp_we      (sp_we),
    .sp_wdata   (sp_wdata),
    .a_we       (a_we),
    .a_wdata    (a_wdata),
    .result     (result),
    .done       (done),
    .busy       (busy),
    .queue_mode (queue_mode)
  );

  always_ff @(posedge clk) begin
    if (rst)            fatal_q <= 1'b0;
    else if (ovf_pulse) fatal_q <= 1'b1;
  end

  assign fatal_ovf = fatal_q;

  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    fatal_ovf |=> fatal_ovf);

  a_r6_no_delivery_from_empty: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy) && stk_we) |-> $past(!q_empty));

endmodule

// File: tb/irq_dispatch_ctrl_bench.sv
module irq_dispatch_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_req_valid = 1'b0;
  logic [15:0] ext_req_msg = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_kind = '0;
  logic [15:0] op_operand = '0;
  logic        insn_done = 1'b0;
  logic [15:0] cpu_pc, cpu_sp, cpu_a;
  logic [15:0] stk_rdata;
  logic        stk_we, stk_re, pc_we, sp_we, a_we, done, busy, queue_mode, fatal_ovf, q_empty;
  logic [15:0] stk_addr, stk_wdata, pc_wdata, sp_wdata, a_wdata, result;

  logic [15:0] smem [256];
  int          wr_seen = 0;
  int          checks = 0;
  int          failures = 0;
  logic [15:0] r, prev_a;
  int          n;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch_ctrl #(.DEPTH(DEPTH), .W(16)) u_irq_dispatch_ctrl (
    .clk(clk), .rst(rst), .ext_req_valid(ext_req_valid), .ext_req_msg(ext_req_msg),
    .op_valid(op_valid), .op_kind(op_kind), .op_operand(op_operand), .insn_done(insn_done),
    .cpu_pc(cpu_pc), .cpu_sp(cpu_sp), .cpu_a(cpu_a), .stk_rdata(stk_rdata),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .a_we(a_we), .a_wdata(a_wdata), .result(result), .done(done), .busy(busy),
    .queue_mode(queue_mode), .fatal_ovf(fatal_ovf), .q_empty(q_empty)
  );

  // core register and stack model
  assign stk_rdata = smem[stk_addr[7:0]];
  always @(posedge clk) begin
    if (rst) begin
      cpu_pc <= 16'h1234;
      cpu_sp <= 16'h0080;
      cpu_a  <= 16'h5555;
    end else begin
      if (pc_we) cpu_pc <= pc_wdata;
      if (sp_we) cpu_sp <= sp_wdata;
      if (a_we)  cpu_a  <= a_wdata;
    end
    if (stk_we) smem[stk_addr[7:0]] <= stk_wdata;
  end

  always @(negedge clk) if (stk_we || pc_we || a_we || sp_we || done) wr_seen <= wr_seen + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] k, input logic [15:0] v, input bit ext_en,
                       input logic [15:0] ext_m, output logic [15:0] res, output int cyc);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_operand = v;
    ext_req_valid = ext_en; ext_req_msg = ext_m;
    @(negedge clk);
    op_valid = 1'b0; ext_req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 10) begin
      @(negedge clk);
      cyc++;
    end
    res = result;
    @(negedge clk);
  endtask

  task automatic push_ext(input logic [15:0] m);
    @(negedge clk);
    ext_req_valid = 1'b1; ext_req_msg = m;
    @(negedge clk);
    ext_req_valid = 1'b0;
  endtask

  task automatic boundary(output int cyc);
    @(negedge clk);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    cyc = 0;
    if (busy) begin
      cyc = 1;
      while (!done && cyc < 10) begin
        @(negedge clk);
        cyc++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(!busy && !queue_mode && !fatal_ovf && q_empty && !done, "R1 reset flags",
        {busy, queue_mode, fatal_ovf, q_empty}, 4'b0001);
    do_op(3'd0, 16'h0, 1'b0, 16'h0, r, n);
    chk(r == 16'h0, "R1 handler reads zero", r, 0);
    chk(n == 1, "R11 read cost", n, 1);
    do_op(3'd1, 16'h0100, 1'b0, 16'h0, r, n);
    chk(n == 1, "R11 write cost", n, 1);
    do_op(3'd0, 16'h0, 1'b0, 16'h0, r, n);
    chk(r == 16'h0100, "R11 handler readback", r, 16'h0100);

    // R5 empty queue: boundary does nothing
    w0 = wr_seen;
    boundary(n);
    chk(n == 0 && wr_seen == w0, "R5 empty queue no delivery", n, 0);

    // R7 detailed delivery
    push_ext(16'hBEEF);
    chk(!q_empty, "R2 queue holds message", q_empty, 0);
    @(negedge clk); insn_done = 1'b1;
    @(negedge clk); insn_done = 1'b0;
    chk(stk_we && stk_addr == 16'h007F && stk_wdata == 16'h1234, "R7 cycle0 push PC",
        {stk_addr, stk_wdata}, {16'h007F, 16'h1234});
    chk(queue_mode, "R7 mode set at cycle0", queue_mode, 1);
    @(negedge clk);
    chk(stk_we && stk_addr == 16'h007E && stk_wdata == 16'h5555, "R7 cycle1 push A",
        {stk_addr, stk_wdata}, {16'h007E, 16'h5555});
    @(negedge clk);
    chk(done && pc_we && pc_wdata == 16'h0100 && a_wdata == 16'hBEEF && sp_wdata == 16'h007E,
        "R7 cycle2 register load", {pc_wdata, a_wdata}, {16'h0100, 16'hBEEF});
    @(negedge clk);
    chk(cpu_pc == 16'h0100 && cpu_a == 16'hBEEF && cpu_sp == 16'h007E && !busy,
        "R7 core state after delivery", {cpu_pc, cpu_a}, {16'h0100, 16'hBEEF});

    // R5 blocked by queue-only mode
    push_ext(16'h0001);
    w0 = wr_seen;
    boundary(n);
    chk(n == 0 && wr_seen == w0 && !q_empty, "R5 held by queue mode", n, 0);

    // R8 return
    do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);
    chk(n == 3, "R8 return cost", n, 3);
    chk(cpu_pc == 16'h1234 && cpu_a == 16'h5555 && cpu_sp == 16'h0080 && !queue_mode,
        "R8 restored state", {cpu_pc, cpu_a}, {16'h1234, 16'h5555});
    boundary(n);
    chk(n == 3 && cpu_a == 16'h0001, "R5 delivery after return", cpu_a, 16'h0001);
    do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);

    // R9 queue control
    do_op(3'd2, 16'h0040, 1'b0, 16'h0, r, n);
    chk(n == 2 && queue_mode, "R9 set mode", {n[15:0], 15'h0, queue_mode}, {16'd2, 16'd1});
    do_op(3'd2, 16'h0000, 1'b0, 16'h0, r, n);
    chk(n == 2 && !queue_mode, "R9 clear mode", {n[15:0], 15'h0, queue_mode}, {16'd2, 16'd0});

    // R10 software interrupt with handler set
    do_op(3'd3, 16'h0077, 1'b0, 16'h0, r, n);
    chk(n == 4 && !q_empty, "R10 enqueue with handler", n, 4);
    boundary(n);
    chk(cpu_a == 16'h0077, "R10 software message delivered", cpu_a, 16'h0077);
    do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);

    // R3 same-cycle enqueue
    do_op(3'd3, 16'h0022, 1'b1, 16'h0011, r, n);
    boundary(n);
    chk(cpu_a == 16'h0011, "R3 external first", cpu_a, 16'h0011);
    do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);
    boundary(n);
    chk(cpu_a == 16'h0022, "R3 software second", cpu_a, 16'h0022);
    do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);

    // R2 order and wrap sweep
    for (int rnd = 0; rnd < 3; rnd++) begin
      for (int k = 0; k < DEPTH - 1; k++) push_ext(16'(rnd * 16 + k + 1));
      chk(!fatal_ovf, "R4 full without overflow", fatal_ovf, 0);
      for (int k = 0; k < DEPTH - 1; k++) begin
        prev_a = cpu_a;
        boundary(n);
        chk(n == 3 && cpu_a == 16'(rnd * 16 + k + 1), "R2 order", cpu_a, 16'(rnd * 16 + k + 1));
        do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);
        chk(cpu_a == prev_a, "R8 A restored", cpu_a, prev_a);
      end
      chk(q_empty, "R2 drained", q_empty, 1);
    end

    // R6 drop with zero handler, R10 ignored enqueue
    do_op(3'd1, 16'h0000, 1'b0, 16'h0, r, n);
    push_ext(16'h0099);
    prev_a = cpu_a;
    w0 = wr_seen;
    boundary(n);
    repeat (3) @(negedge clk);
    chk(n == 0 && wr_seen == w0 && q_empty && cpu_a == prev_a && !queue_mode,
        "R6 message dropped", {q_empty, 15'h0, cpu_a}, {1'b1, 15'h0, prev_a});
    do_op(3'd3, 16'h0055, 1'b0, 16'h0, r, n);
    chk(n == 4 && q_empty, "R10 no enqueue without handler", q_empty, 1);
    do_op(3'd1, 16'h0100, 1'b0, 16'h0, r, n);
    push_ext(16'h0042);
    boundary(n);
    chk(cpu_a == 16'h0042, "R6 dropped message not delivered", cpu_a, 16'h0042);
    do_op(3'd4, 16'h0, 1'b0, 16'h0, r, n);

    // R12 unused codes
    for (int c = 5; c < 8; c++) begin
      do_op(3'(c), 16'hFFFF, 1'b0, 16'h0, r, n);
      chk(n == 1 && !queue_mode, "R12 unused code", n, 1);
      do_op(3'd0, 16'h0, 1'b0, 16'h0, r, n);
      chk(r == 16'h0100, "R12 handler untouched", r, 16'h0100);
    end

    // R4 overflow
    for (int k = 0; k < DEPTH - 1; k++) push_ext(16'(k + 1));
    chk(!fatal_ovf, "R4 no flag at capacity", fatal_ovf, 0);
    push_ext(16'h00AA);
    chk(fatal_ovf, "R4 flag on overflow", fatal_ovf, 1);
    repeat (4) @(negedge clk);
    chk(fatal_ovf, "R4 flag sticky", fatal_ovf, 1);

    do_reset();
    @(negedge clk);
    chk(!fatal_ovf && q_empty && !queue_mode && !busy, "R1 reset clears flags",
        {fatal_ovf, q_empty}, 2'b01);
    do_op(3'd0, 16'h0, 1'b0, 16'h0, r, n);
    chk(r == 16'h0, "R1 handler cleared by reset", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule